// File: doc/BRIEF.md
# Double-Buffered Audio DMA Interface

This block is the register-programmed front end of a stereo audio output path. Software gives it a buffer as a start address followed by a byte length. The block keeps up to two such buffers in a small queue, so the next buffer can be loaded while the current one is still playing. A programmable divider paces playback. On every pacing tick the block issues one 32-bit read on a simple memory read port. Each returned word is one stereo frame of signed 16-bit big-endian samples, and the block splits it into a left and a right sample.

A second divider toggles a serial bit clock. Software computes both divider values from the 48,681,812 Hz converter clock and the chosen sample rate (8 kHz to 48 kHz). The rate divider holds the clock-to-sample-rate ratio minus one. The bit-clock divider holds that value divided by 66, minus one, capped at 15.

The interrupt request runs one buffer behind. It is raised when a finished buffer hands over to the entry queued after it. A write of any value to the status register acknowledges it. When the queue runs dry, the sample outputs keep the last frame.

Top module: `audio_dma_if`

## Requirements
- R1: After a synchronous reset, the following all read zero: status, control, the rate and bit-clock registers, the sample outputs, `smp_strobe`, `bclk`, `irq` and `mem_rd`.
- R2: Registers use word indices. 0 is the staged buffer address and 1 is the length. 2 is control, where bit 0 is the playback enable. 3 is status, 4 is the rate divider and 5 is the bit-clock divider. Index 0 reads back the staged address, and index 1 reads back the remaining bytes of the playing buffer (0 when idle).
- R3: A write to index 1 queues the pair (staged address, written length with bits 1:0 cleared). A length that is zero after clearing is ignored.
- R4: Status bit 31 is high when two buffers are queued. Status bit 30 is high while any queued buffer has bytes left. All other status bits read zero.
- R5: A length write while two buffers are queued is dropped. The full flag stays set and the queued buffers are unchanged.
- R6: While enabled, one read is issued every rate+1 cycles, provided a buffer is queued. The read uses the playing buffer's current address, which then steps by 4 while the remaining length drops by 4. With the enable clear, no read is issued.
- R7: One cycle after a memory response, `smp_left` takes rdata[31:16] and `smp_right` takes rdata[15:0], and `smp_strobe` pulses for that cycle. Without a response, both samples hold their value.
- R8: `irq` rises one cycle after the last frame of the playing buffer is read, if another buffer (already queued, or written in that same cycle) takes over. A buffer that enters an empty queue raises no interrupt.
- R9: A write of any value to index 3 clears `irq`. A takeover in the same cycle wins.
- R10: While enabled, `bclk` toggles every bit-clock divider + 1 cycles. While disabled, it is held low.
- R11: The bit-clock divider keeps only written bits 3:0, so its largest value is 15.
- R12: The rate divider keeps only written bits 13:0, which covers 8 kHz against the 48.68 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_idx`) |
| mem_rd | output | 1 | Memory read request, one cycle per frame |
| mem_addr | output | 32 | Byte address of the frame being read |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response word, big-endian left/right pair |
| smp_left | output | 16 | Left sample |
| smp_right | output | 16 | Right sample |
| smp_strobe | output | 1 | New frame on the sample outputs |
| bclk | output | 1 | Serial bit clock |
| irq | output | 1 | Buffer-takeover interrupt request |

## Verification
Each result has a fixed cycle in which it is due. `mem_rd` and `mem_addr` are valid in the same cycle that the pacing count reaches zero. The sample outputs, `smp_strobe` and `irq` change one edge after the response or the last-frame read that causes them. Register reads are combinational, and a queued length is visible in status one edge after its write. The bench keeps a behavioural model that advances on each rising edge from the same inputs, and it compares every output on the falling edge that follows, so every result is checked in the cycle it is due. Register and status reads are sampled between edges and compared against the model's queue.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;

    localparam int REG_W       = 32;
    localparam int IDX_W       = 3;
    localparam int ADDR_W      = 32;
    localparam int LEN_W       = 18;
    localparam int RATE_W      = 14;
    localparam int BDIV_W      = 4;
    localparam int SMP_W       = 16;
    localparam int FRAME_BYTES = 2 * SMP_W / 8;
    localparam int STAT_FULL   = 31;
    localparam int STAT_BUSY   = 30;

    typedef enum logic [IDX_W-1:0] {
        IDX_ADDR = 3'd0,
        IDX_LEN  = 3'd1,
        IDX_CTRL = 3'd2,
        IDX_STAT = 3'd3,
        IDX_RATE = 3'd4,
        IDX_BDIV = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
    } buf_ent_t;

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } frame_t;

    function automatic frame_t split_frame(input logic [REG_W-1:0] w);
        frame_t f;
        f.left  = w[REG_W-1:SMP_W];
        f.right = w[SMP_W-1:0];
        return f;
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input logic [LEN_W-1:0] l);
        return l & ~LEN_W'(FRAME_BYTES - 1);
    endfunction

endpackage

// File: rtl/audio_dma_div.sv
module audio_dma_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);
    logic [W-1:0] cnt;

    assign tick_o = run_i && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (!run_i || tick_o) cnt <= limit_i;
        else                     cnt <= cnt - 1'b1;
    end

    // R6 / R10: a nonzero divider never gives back-to-back ticks
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_o && limit_i != '0) |=> !tick_o);

endmodule

// File: rtl/audio_dma_queue.sv
module audio_dma_queue
    import audio_dma_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     push_i,
    input  buf_ent_t push_ent_i,
    input  logic     consume_i,
    output buf_ent_t head_o,
    output logic     head_v_o,
    output logic     full_o,
    output logic     takeover_o
);
    localparam logic [LEN_W-1:0]  STEP_L = LEN_W'(FRAME_BYTES);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(FRAME_BYTES);

    buf_ent_t head_q, nxt_q;
    logic     head_v, nxt_v, push_ok, last;

    assign full_o     = head_v && nxt_v;
    assign push_ok    = push_i && !full_o;
    assign last       = head_q.rem == STEP_L;
    assign takeover_o = consume_i && last && (nxt_v || push_ok);
    assign head_o     = head_q;
    assign head_v_o   = head_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_v <= 1'b0;
            nxt_v  <= 1'b0;
            head_q <= '0;
            nxt_q  <= '0;
        end else if (consume_i) begin
            if (last) begin
                if (nxt_v) begin
                    head_q <= nxt_q;
                    nxt_v  <= 1'b0;
                end else if (push_ok) begin
                    head_q <= push_ent_i;
                end else begin
                    head_v <= 1'b0;
                end
            end else begin
                head_q.addr <= head_q.addr + STEP_A;
                head_q.rem  <= head_q.rem - STEP_L;
                if (push_ok) begin
                    nxt_q <= push_ent_i;
                    nxt_v <= 1'b1;
                end
            end
        end else if (push_ok) begin
            if (!head_v) begin
                head_q <= push_ent_i;
                head_v <= 1'b1;
            end else begin
                nxt_q <= push_ent_i;
                nxt_v <= 1'b1;
            end
        end
    end

    // R5: a full queue stays full unless a buffer completes
    p_full_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (full_o && !(consume_i && last)) |=> full_o);
    // R3: an accepted push always leaves a playing buffer
    p_push_lands_r3: assert property (@(posedge clk) disable iff (rst)
        push_ok |=> head_v_o);

endmodule

// File: rtl/audio_dma_if.sv
module audio_dma_if
    import audio_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [REG_W-1:0]  mem_rdata,
    output logic [SMP_W-1:0]  smp_left,
    output logic [SMP_W-1:0]  smp_right,
    output logic              smp_strobe,
    output logic              bclk,
    output logic              irq
);
    reg_idx_e          idx;
    logic [ADDR_W-1:0] staged_addr;
    logic              en;
    logic [RATE_W-1:0] rate;
    logic [BDIV_W-1:0] bdiv;
    logic              smp_tick, bclk_tick, consume, push, full, head_v, takeover;
    logic [LEN_W-1:0]  wlen;
    buf_ent_t          head, push_ent;
    frame_t            frame;

    assign idx      = reg_idx_e'(reg_idx);
    assign wlen     = frame_len(reg_wdata[LEN_W-1:0]);
    assign push     = reg_we && idx == IDX_LEN && wlen != '0;
    assign push_ent = '{addr: staged_addr, rem: wlen};
    assign consume  = smp_tick && head_v;
    assign mem_rd   = consume;
    assign mem_addr = head.addr;

    audio_dma_div #(.W(RATE_W)) u_rate_div (
        .clk(clk), .rst(rst), .run_i(en), .limit_i(rate), .tick_o(smp_tick));

    audio_dma_div #(.W(BDIV_W)) u_bclk_div (
        .clk(clk), .rst(rst), .run_i(en), .limit_i(bdiv), .tick_o(bclk_tick));

    audio_dma_queue u_queue (
        .clk(clk), .rst(rst), .push_i(push), .push_ent_i(push_ent),
        .consume_i(consume), .head_o(head), .head_v_o(head_v),
        .full_o(full), .takeover_o(takeover));

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_addr <= '0;
            en          <= 1'b0;
            rate        <= '0;
            bdiv        <= '0;
        end else if (reg_we) begin
            case (idx)
                IDX_ADDR: staged_addr <= reg_wdata[ADDR_W-1:0];
                IDX_CTRL: en          <= reg_wdata[0];
                IDX_RATE: rate        <= reg_wdata[RATE_W-1:0];
                IDX_BDIV: bdiv        <= reg_wdata[BDIV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq        <= 1'b0;
            frame      <= '0;
            smp_strobe <= 1'b0;
            bclk       <= 1'b0;
        end else begin
            if (takeover)                         irq <= 1'b1;
            else if (reg_we && idx == IDX_STAT)   irq <= 1'b0;
            smp_strobe <= mem_rvalid;
            if (mem_rvalid) frame <= split_frame(mem_rdata);
            if (!en)            bclk <= 1'b0;
            else if (bclk_tick) bclk <= ~bclk;
        end
    end

    assign smp_left  = frame.left;
    assign smp_right = frame.right;

    always_comb begin
        reg_rdata = '0;
        case (idx)
            IDX_ADDR: reg_rdata = staged_addr;
            IDX_LEN:  reg_rdata = head_v ? REG_W'(head.rem) : '0;
            IDX_CTRL: reg_rdata = REG_W'(en);
            IDX_STAT: begin
                reg_rdata[STAT_FULL] = full;
                reg_rdata[STAT_BUSY] = head_v;
            end
            IDX_RATE: reg_rdata = REG_W'(rate);
            IDX_BDIV: reg_rdata = REG_W'(bdiv);
            default:  reg_rdata = '0;
        endcase
    end

    // R9: an acknowledge without a takeover clears the request
    p_irq_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_we && idx == IDX_STAT && !takeover) |=> !irq);
    // R7: samples only move on a memory response
    p_smp_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !mem_rvalid |=> $stable({smp_left, smp_right}));
    // R10: the bit clock idles low while playback is off
    p_bclk_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> !bclk);
    // R6: a read is only issued while a buffer is playing
    p_rd_busy_r6: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> reg_idx != 3'd3 || reg_rdata[STAT_BUSY]);

endmodule

// File: tb/audio_dma_if_bench.sv
module audio_dma_if_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] smp_left, smp_right;
    logic        smp_strobe, bclk, irq;

    always #2.5 clk = ~clk;

    audio_dma_if u_audio_dma_if (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .smp_left(smp_left), .smp_right(smp_right), .smp_strobe(smp_strobe),
        .bclk(bclk), .irq(irq));

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference model
    int unsigned qa[$];
    int unsigned ql[$];
    int unsigned m_staged, m_rate, m_bdiv, m_pace, m_bcnt;
    bit m_en, m_irq, m_bclk, m_stb;
    logic [15:0] m_l, m_r;

    // memory pipe
    bit p0_v, p1_v;
    logic [31:0] p0_a, p1_a;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hA5A5, ~a[15:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_rd();
        return m_en && m_pace == 0 && qa.size() > 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            qa.delete(); ql.delete();
            m_staged = 0; m_rate = 0; m_bdiv = 0; m_pace = 0; m_bcnt = 0;
            m_en = 0; m_irq = 0; m_bclk = 0; m_stb = 0; m_l = 0; m_r = 0;
        end else begin
            bit consume, last, push_ok, take;
            int unsigned wl;
            consume = exp_rd();
            last    = consume && ql[0] == 4;
            wl      = reg_wdata[17:0] & 32'h3FFFC;
            push_ok = reg_we && reg_idx == 3'd1 && wl != 0 && qa.size() < 2;
            take    = last && (qa.size() == 2 || push_ok);
            if (consume) begin
                if (last) begin
                    void'(qa.pop_front()); void'(ql.pop_front());
                end else begin
                    qa[0] = qa[0] + 4; ql[0] = ql[0] - 4;
                end
            end
            if (push_ok) begin qa.push_back(m_staged); ql.push_back(wl); end
            if (take) m_irq = 1;
            else if (reg_we && reg_idx == 3'd3) m_irq = 0;
            m_stb = mem_rvalid;
            if (mem_rvalid) begin m_l = mem_rdata[31:16]; m_r = mem_rdata[15:0]; end
            if (!m_en || m_pace == 0) m_pace = m_rate; else m_pace--;
            if (!m_en) begin m_bclk = 0; m_bcnt = m_bdiv; end
            else if (m_bcnt == 0) begin m_bcnt = m_bdiv; m_bclk = !m_bclk; end
            else m_bcnt--;
            if (reg_we) begin
                case (reg_idx)
                    3'd0: m_staged = reg_wdata;
                    3'd2: m_en = reg_wdata[0];
                    3'd4: m_rate = reg_wdata[13:0];
                    3'd5: m_bdiv = reg_wdata[3:0];
                    default: ;
                endcase
            end
        end
        started = 1;
        cyc++;
        if (cyc > 150000 && !done) begin
            check(0, "WDOG", "watchdog expired", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // per-cycle comparison, then memory response driving
    always @(negedge clk) begin
        if (started && !rst) begin
            check(mem_rd == exp_rd(), "R6", "mem_rd", mem_rd, exp_rd());
            if (exp_rd()) check(mem_addr == qa[0], "R6", "mem_addr", mem_addr, qa[0]);
            check(irq == m_irq, "R8", "irq", irq, m_irq);
            check(smp_left == m_l && smp_right == m_r, "R7", "samples",
                  {smp_left, smp_right}, {m_l, m_r});
            check(smp_strobe == m_stb, "R7", "strobe", smp_strobe, m_stb);
            check(bclk == m_bclk, "R10", "bclk", bclk, m_bclk);
        end
        mem_rvalid = p1_v && !rst;
        mem_rdata  = p1_v ? mem_word(p1_a) : 32'h0;
        p1_v = p0_v; p1_a = p0_a;
        p0_v = mem_rd === 1'b1 && !rst; p0_a = mem_addr;
    end

    task automatic wr(input logic [2:0] i, input logic [31:0] v);
        @(negedge clk); #1;
        reg_we = 1; reg_idx = i; reg_wdata = v;
        @(negedge clk); #1;
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] i, output logic [31:0] v);
        @(negedge clk); #1;
        reg_idx = i;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] exp_status();
        return {qa.size() == 2, qa.size() > 0, 30'b0};
    endfunction

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        // R1 reset state
        rd(3'd3, v); check(v == 0, "R1", "status after reset", v, 0);
        rd(3'd2, v); check(v == 0, "R1", "control after reset", v, 0);
        rd(3'd4, v); check(v == 0, "R1", "rate after reset", v, 0);
        check(!irq && !mem_rd && !bclk && smp_left == 0, "R1", "outputs after reset",
              {irq, mem_rd, bclk}, 0);
        // R2 / R11 / R12 register access
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); check(v == 32'h3FFF, "R12", "rate width", v, 32'h3FFF);
        wr(3'd5, 32'h0000_001F); rd(3'd5, v); check(v == 32'hF, "R11", "bclk divider cap", v, 32'hF);
        wr(3'd4, 3); wr(3'd5, 1);
        rd(3'd4, v); check(v == 3, "R2", "rate readback", v, 3);
        wr(3'd0, 32'h0000_0100); rd(3'd0, v); check(v == 32'h100, "R2", "staged addr", v, 32'h100);
        // R3 zero length ignored, low bits cleared
        wr(3'd1, 32'h3); rd(3'd3, v); check(v == 0, "R3", "zero length ignored", v, 0);
        wr(3'd1, 32'h13); rd(3'd1, v); check(v == 32'h10, "R3", "length masked", v, 32'h10);
        rd(3'd3, v); check(v == 32'h4000_0000, "R4", "busy only", v, 32'h4000_0000);
        wr(3'd0, 32'h0000_0200); wr(3'd1, 8);
        rd(3'd3, v); check(v == 32'hC000_0000, "R4", "full and busy", v, 32'hC000_0000);
        // R5 push while full dropped
        wr(3'd0, 32'h0000_0900); wr(3'd1, 64);
        rd(3'd3, v); check(v == 32'hC000_0000, "R5", "full stays", v, 32'hC000_0000);
        rd(3'd1, v); check(v == 32'h10, "R5", "head unchanged", v, 32'h10);
        // R6 / R8 playback
        wr(3'd2, 1);
        rd(3'd3, v); check(irq == 0, "R8", "no irq on start", irq, 0);
        for (int k = 0; k < 400 && !irq; k++) @(negedge clk);
        check(irq == 1, "R8", "irq on takeover", irq, 1);
        rd(3'd1, v); check(v == 8 || v == 4, "R8", "second buffer playing", v, 8);
        wr(3'd3, 32'hDEAD_BEEF);
        check(irq == 0, "R9", "irq acknowledged", irq, 0);
        // R6 disable stops reads
        wr(3'd0, 32'h0000_1000); wr(3'd1, 32'h100);
        repeat (10) @(negedge clk);
        wr(3'd2, 0);
        rd(3'd1, v);
        repeat (40) @(negedge clk);
        begin
            logic [31:0] v2;
            rd(3'd1, v2); check(v2 == v, "R6", "no progress while disabled", v2, v);
        end
        wr(3'd2, 1);
        // random traffic
        for (int it = 0; it < 6000; it++) begin
            @(negedge clk); #1;
            if (irq && $urandom_range(0, 3) == 0) wr(3'd3, $urandom());
            else if (qa.size() < 2 && $urandom_range(0, 5) == 0) begin
                wr(3'd0, $urandom() & 32'hFFFF_FFFC);
                wr(3'd1, $urandom_range(0, 40));
            end else if ($urandom_range(0, 200) == 0) wr(3'd4, $urandom_range(0, 5));
            else if ($urandom_range(0, 300) == 0) wr(3'd5, $urandom_range(0, 3));
            else if ($urandom_range(0, 400) == 0) wr(3'd2, $urandom_range(0, 1));
            else if ($urandom_range(0, 20) == 0) begin
                rd(3'd3, v);
                check(v == exp_status(), "R4", "status in traffic", v, exp_status());
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule